// File: doc/BRIEF.md
# Periodic Conversion Trigger Generator

This block produces the conversion strobes that advance a converter's sample FIFO. A user trigger starts things off. That trigger is either the rising edge of a hardware line or a single-cycle software strobe, and a select input decides which one is used. When periodic operation is off, every selected user trigger passes straight through as one trigger pulse. When periodic operation is on, the first user trigger is passed through and starts a sequence. The block then issues internal triggers on its own, one every `period + 1` clock cycles. The sequence runs for a programmed number of internal triggers, or without end when that number is zero.

A sequence ends in one of four ways: the count runs out, the periodic enable is dropped, the FIFO is flushed, or the block is reset by software. On a count exhaustion or an enable drop, the block waits for the converter's busy indication to fall and then sets a sticky completion flag. A flush or a software reset stops the sequence in the same cycle. The interval and count are captured at the first trigger, so the inputs may change while a sequence runs.

The controller is a three-state machine:
- `ST_IDLE` waits for a user trigger. It takes the passthrough transition when periodic operation is off and the start transition (into `ST_RUN`) when it is on.
- `ST_RUN` counts intervals. It takes the fire transition when an interval expires. It takes the exhaust transition (into `ST_DRAIN`) on the last counted trigger, and the abort transition (into `ST_DRAIN`) when the enable is low.
- `ST_DRAIN` waits for the converter to go idle. It then takes the complete transition back to `ST_IDLE`, which sets the flag.
- A kill transition, caused by a flush or a software reset, returns any state to `ST_IDLE`.

Top module: `pdac_trig_gen`

## Requirements
- R1: After `rst_n` is released, `trig_o` and `done_o` are both 0 and the block is idle.
- R2: With `src_sel` = 0, a rising edge on `hw_trig` is the user trigger and `sw_trig` has no effect. With `src_sel` = 1, a high `sw_trig` is the user trigger and `hw_trig` has no effect.
- R3: With `per_en` low, each user trigger produces exactly one `trig_o` pulse in the following cycle.
- R4: With `per_en` high, a user trigger in idle produces a `trig_o` pulse in the next cycle. Internal pulses then follow every `period_i + 1` cycles.
- R5: With `count_i` = N > 0, exactly N internal pulses follow the first one. If `conv_busy` is low, `done_o` rises in the cycle after the last pulse.
- R6: With `count_i` = 0, internal pulses continue without limit while `per_en` stays high.
- R7: When `per_en` is low during a sequence, no further pulse is issued, even if an interval expires in that same cycle, and the sequence drains to completion.
- R8: A draining sequence sets `done_o` only once `conv_busy` is low, in the cycle after that is seen.
- R9: User triggers that arrive while a sequence is running or draining are ignored.
- R10: `fifo_rst` ends any sequence at once. No pulse follows, and `done_o` keeps its value.
- R11: `sw_rst` ends any sequence at once, no pulse follows, and `done_o` is cleared.
- R12: `done_o` holds until `done_clr` or `sw_rst`. A completion in the same cycle as `done_clr` leaves `done_o` set.
- R13: `period_i` and `count_i` are captured at the first trigger. Changing them mid-sequence does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rst | input | 1 | FIFO flush; ends a sequence |
| sw_rst | input | 1 | Software reset; ends a sequence and clears the flag |
| src_sel | input | 1 | User trigger source: 0 hardware, 1 software |
| hw_trig | input | 1 | Hardware trigger line (rising edge used) |
| sw_trig | input | 1 | Software trigger strobe |
| per_en | input | 1 | Periodic operation enable |
| period_i | input | CNT_W | Interval minus one, in clock cycles |
| count_i | input | CNT_W | Number of internal triggers; 0 = endless |
| conv_busy | input | 1 | Converter busy with the current conversion |
| done_clr | input | 1 | Clears the completion flag |
| trig_o | output | 1 | One-cycle conversion trigger to the FIFO |
| done_o | output | 1 | Sticky periodic-sequence completion flag |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is an expiring interval and a dropped enable. The bench provokes it by clearing `per_en` exactly one cycle before each endless-sequence pulse is due, for every interval in the swept range. It judges the outcome by requiring that pulse to be absent and the flag to rise two cycles later.

The second pair is a completion and a flag clear. The bench holds `done_clr` high across a whole sequence. It expects `done_o` to be 1 in the cycle after the drain and 0 in the cycle after that.

// File: rtl/pdac_trig_pkg.sv
package pdac_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } trig_state_e;

endpackage

// File: rtl/pdac_src_pick.sv
module pdac_src_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic hw_trig,
    input  logic sw_trig,
    output logic user_trig
);

    logic hw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_q <= 1'b0;
        end else begin
            hw_q <= hw_trig;
        end
    end

    // hardware line contributes on its rising edge only
    always_comb begin
        if (src_sel) begin
            user_trig = sw_trig;
        end else begin
            user_trig = hw_trig & ~hw_q;
        end
    end

endmodule

// File: rtl/pdac_interval.sv
module pdac_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic             reload,
    input  logic [CNT_W-1:0] period_in,
    output logic             expired
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= ZERO;
            cnt_q <= ZERO;
        end else if (clear) begin
            per_q <= ZERO;
            cnt_q <= ZERO;
        end else if (start) begin
            per_q <= period_in;
            cnt_q <= period_in;
        end else if (reload) begin
            cnt_q <= per_q;
        end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == ZERO);

endmodule

// File: rtl/pdac_quota.sv
module pdac_quota #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic             consume,
    input  logic [CNT_W-1:0] num_in,
    output logic             endless,
    output logic             last
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] rem_q;
    logic             endless_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= ZERO;
            endless_q <= 1'b0;
        end else if (clear) begin
            rem_q     <= ZERO;
            endless_q <= 1'b0;
        end else if (start) begin
            rem_q     <= num_in;
            endless_q <= (num_in == ZERO);
        end else if (consume && rem_q != ZERO) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign endless = endless_q;
    assign last    = (rem_q == ONE);

endmodule

// File: rtl/pdac_trig_gen.sv
module pdac_trig_gen
    import pdac_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_rst,
    input  logic             sw_rst,
    input  logic             src_sel,
    input  logic             hw_trig,
    input  logic             sw_trig,
    input  logic             per_en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             conv_busy,
    input  logic             done_clr,
    output logic             trig_o,
    output logic             done_o
);

    trig_state_e state_q;
    trig_state_e state_d;

    logic user_trig;
    logic kill;
    logic expired;
    logic endless;
    logic last;
    logic fire;
    logic start;
    logic reload;
    logic consume;
    logic done_set;

    assign kill = fifo_rst | sw_rst;

    pdac_src_pick u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .hw_trig   (hw_trig),
        .sw_trig   (sw_trig),
        .user_trig (user_trig)
    );

    pdac_interval #(.CNT_W(CNT_W)) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (kill),
        .start     (start),
        .reload    (reload),
        .period_in (period_i),
        .expired   (expired)
    );

    pdac_quota #(.CNT_W(CNT_W)) u_quota (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (kill),
        .start   (start),
        .consume (consume),
        .num_in  (count_i),
        .endless (endless),
        .last    (last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and per-cycle controls
    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        start    = 1'b0;
        reload   = 1'b0;
        consume  = 1'b0;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (user_trig) begin
                    fire = 1'b1;                 // passthrough or start
                    if (per_en) begin
                        start   = 1'b1;
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!per_en) begin
                    state_d = ST_DRAIN;          // abort beats expiry
                end else if (expired) begin
                    fire   = 1'b1;
                    reload = 1'b1;
                    if (!endless) begin
                        consume = 1'b1;
                        if (last) begin
                            state_d = ST_DRAIN;  // exhaust
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (!conv_busy) begin
                    done_set = 1'b1;
                    state_d  = ST_IDLE;          // complete
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (kill) begin
            state_d  = ST_IDLE;
            fire     = 1'b0;
            start    = 1'b0;
            reload   = 1'b0;
            consume  = 1'b0;
            done_set = 1'b0;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            trig_o <= fire;
            if (sw_rst) begin
                done_o <= 1'b0;
            end else if (done_set) begin
                done_o <= 1'b1;
            end else if (done_clr) begin
                done_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pdac_trig_checker.sv
module pdac_trig_checker
    import pdac_trig_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_rst,
    input logic        sw_rst,
    input logic        per_en,
    input logic        conv_busy,
    input logic        done_clr,
    input logic        trig_o,
    input logic        done_o,
    input trig_state_e state
);

    AST_KILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rst || sw_rst) |=> !trig_o); // R10

    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !done_o); // R11

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !done_clr && !sw_rst) |=> done_o); // R12

    AST_DONE_AFTER_IDLE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(state) == ST_DRAIN && !$past(conv_busy))); // R8

    AST_DRAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> !trig_o); // R7

    AST_ABORT_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !per_en) |=> !trig_o); // R7

endmodule

bind pdac_trig_gen pdac_trig_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_rst  (fifo_rst),
    .sw_rst    (sw_rst),
    .per_en    (per_en),
    .conv_busy (conv_busy),
    .done_clr  (done_clr),
    .trig_o    (trig_o),
    .done_o    (done_o),
    .state     (state_q)
);

// File: tb/pdac_trig_gen_bench.sv
`timescale 1ns/100ps
module pdac_trig_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_rst = 1'b0;
    logic        sw_rst = 1'b0;
    logic        src_sel = 1'b1;
    logic        hw_trig = 1'b0;
    logic        sw_trig = 1'b0;
    logic        per_en = 1'b0;
    logic [15:0] period_i = '0;
    logic [15:0] count_i = '0;
    logic        conv_busy = 1'b0;
    logic        done_clr = 1'b0;
    logic        trig_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pdac_trig_gen u_pdac_trig_gen (
        .clk(clk), .rst_n(rst_n), .fifo_rst(fifo_rst), .sw_rst(sw_rst),
        .src_sel(src_sel), .hw_trig(hw_trig), .sw_trig(sw_trig),
        .per_en(per_en), .period_i(period_i), .count_i(count_i),
        .conv_busy(conv_busy), .done_clr(done_clr),
        .trig_o(trig_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_user(input logic v);
        if (src_sel) sw_trig = v;
        else         hw_trig = v;
    endtask

    task automatic soft_reset();
        @(negedge clk) sw_rst = 1'b1;
        @(negedge clk) sw_rst = 1'b0;
    endtask

    // finite sequence; extra user trigger mid-run (R9), inputs changed mid-run (R13)
    task automatic run_finite(input int p, input int n, input logic sel);
        int last_c;
        soft_reset();
        src_sel = sel; per_en = 1'b1;
        period_i = 16'(p); count_i = 16'(n);
        set_user(1'b1);
        last_c = 1 + n * (p + 1);
        for (int c = 1; c <= last_c + 4; c++) begin
            @(negedge clk);
            chk("R4/R13 trigger", trig_o,
                ((c - 1) % (p + 1) == 0) && ((c - 1) / (p + 1) <= n));
            chk("R5 done", done_o, c >= last_c + 1);
            if (c == 1) begin set_user(1'b0); period_i = 16'(p + 5); count_i = 16'(n + 4); end
            if (c == 2) set_user(1'b1);
            if (c == 3) set_user(1'b0);
        end
    endtask

    // endless sequence aborted exactly when a pulse is due (R6, R7)
    task automatic run_endless(input int p, input logic sel);
        int a;
        soft_reset();
        src_sel = sel; per_en = 1'b1;
        period_i = 16'(p); count_i = 16'd0;
        set_user(1'b1);
        a = 3 * (p + 1);
        for (int c = 1; c <= a + 5; c++) begin
            @(negedge clk);
            chk("R6/R7 trigger", trig_o, ((c - 1) % (p + 1) == 0) && (c <= a));
            chk("R7 done", done_o, c >= a + 2);
            if (c == 1) set_user(1'b0);
            if (c == 2) set_user(1'b1);
            if (c == 3) set_user(1'b0);
            if (c == a) per_en = 1'b0;
        end
    endtask

    // periodic off: one strobe on the chosen line, expect pulse or not (R2, R3)
    task automatic pass_one(input logic sel, input logic use_hw, input logic exp);
        per_en = 1'b0; src_sel = sel;
        @(negedge clk);
        if (use_hw) hw_trig = 1'b1; else sw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0; sw_trig = 1'b0;
        chk("R2/R3 passthrough", trig_o, exp);
        @(negedge clk);
        chk("R3 single pulse", trig_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 trig after reset", trig_o, 1'b0);
        chk("R1 done after reset", done_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 trig idle", trig_o, 1'b0);

        pass_one(1'b1, 1'b0, 1'b1);
        pass_one(1'b1, 1'b1, 1'b0);
        pass_one(1'b0, 1'b1, 1'b1);
        pass_one(1'b0, 1'b0, 1'b0);

        // back-to-back software strobes with periodic off (R3)
        per_en = 1'b0; src_sel = 1'b1;
        @(negedge clk) sw_trig = 1'b1;
        @(negedge clk) chk("R3 first strobe", trig_o, 1'b1);
        @(negedge clk) sw_trig = 1'b0;
        chk("R3 second strobe", trig_o, 1'b1);
        @(negedge clk) chk("R3 quiet", trig_o, 1'b0);

        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++)
                for (int n = 1; n < 4; n++)
                    run_finite(p, n, logic'(s));
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++)
                run_endless(p, logic'(s));

        // R8: drain waits for converter idle
        soft_reset();
        src_sel = 1'b1; per_en = 1'b1; conv_busy = 1'b1;
        period_i = 16'd1; count_i = 16'd1;
        sw_trig = 1'b1;
        for (int c = 1; c <= 9; c++) begin
            @(negedge clk);
            chk("R8 trigger", trig_o, c == 1 || c == 3);
            chk("R8 done", done_o, c >= 7);
            if (c == 1) sw_trig = 1'b0;
            if (c == 6) conv_busy = 1'b0;
        end

        // R10: flush mid-run, flag (set above) kept
        period_i = 16'd2; count_i = 16'd0;
        sw_trig = 1'b1;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            chk("R10 trigger", trig_o, c == 1 || c == 4);
            chk("R10 done kept", done_o, 1'b1);
            if (c == 1) sw_trig = 1'b0;
            if (c == 4) fifo_rst = 1'b1;
            if (c == 5) fifo_rst = 1'b0;
        end

        // R11: software reset mid-run clears flag
        sw_trig = 1'b1;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            chk("R11 trigger", trig_o, c == 1);
            chk("R11 done", done_o, c <= 2);
            if (c == 1) sw_trig = 1'b0;
            if (c == 2) sw_rst = 1'b1;
            if (c == 3) sw_rst = 1'b0;
        end

        // R12: completion coinciding with clear keeps flag set
        period_i = 16'd0; count_i = 16'd1;
        done_clr = 1'b1; sw_trig = 1'b1;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            chk("R12 set beats clear", done_o, c == 3);
            if (c == 1) sw_trig = 1'b0;
        end
        done_clr = 1'b0;

        // R12: sticky without clear, then cleared
        sw_trig = 1'b1;
        for (int c = 1; c <= 9; c++) begin
            @(negedge clk);
            chk("R12 sticky", done_o, c >= 3);
            if (c == 1) sw_trig = 1'b0;
        end
        done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        chk("R12 cleared", done_o, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule